// File: doc/BRIEF.md
# Gated Dual-Channel Waveform Playback

This block holds one pulse shape in an on-chip memory with two ports and replays it onto two DAC output lanes while a pulse window is open. The control side loads or rewrites words at any time through a write port with its own address, 32-bit data and write strobe. The playback side receives, every clock, a sample index and a window flag from an external pulse timing counter. The low bits of the index address the memory, and each returned word is split into two 14-bit DAC codes.

The memory read costs one cycle, so a two-state machine delays the window flag by the same cycle. In state `ST_IDLE` both lanes carry a fixed idle code, set by parameter and 0 by default. In state `ST_PLAY` they carry the unpacked memory word. The transition `ST_IDLE -> ST_PLAY` is taken on any clock where the window flag is high. The transition `ST_PLAY -> ST_IDLE` is taken on any clock where it is low. Each state holds while the flag keeps its level, and reset forces `ST_IDLE`. A host write and a playback read of the same word in one cycle return the word as it was before the write.

Top module: `wave_playback`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), and after it is released until a window is sampled high, both `dac_a` and `dac_b` equal `IDLE_CODE`.
- R2: When `play_win` is high in cycle t with index i, `dac_a` in cycle t+1 equals bits [13:0] of the word stored at address i.
- R3: Under the same condition, `dac_b` in cycle t+1 equals bits [29:16] of that word.
- R4: Word bits [15:14] and [31:30] never reach either output: two words that differ only there produce identical lane codes.
- R5: When `play_win` is low in cycle t, both lanes in cycle t+1 equal `IDLE_CODE` (default 0), whatever the memory holds and whatever the host writes.
- R6: The read address is `play_idx` modulo `DEPTH` (its low log2(DEPTH) bits, DEPTH = 1024 by default). Higher index bits are ignored.
- R7: A host write in cycle t is returned by a playback read of that address issued in any later cycle, including while the window is open.
- R8: When the host writes the address being read in the same cycle, that read returns the word held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both memory ports and the control logic |
| rst_n | input | 1 | Synchronous active-low reset of the gating state |
| host_we | input | 1 | Host write strobe |
| host_addr | input | log2(DEPTH) | Host write word address |
| host_wdata | input | 32 | Host write data (lane A in [13:0], lane B in [29:16]) |
| play_idx | input | IDX_W (16) | Pulse-relative sample index from the timing counter |
| play_win | input | 1 | Pulse window active flag |
| dac_a | output | 14 | DAC lane A code |
| dac_b | output | 14 | DAC lane B code |

## Verification
Two functions of this block can land in the same cycle: a host write and a playback read of the same word. The bench provokes this by writing the address that the index is selecting while the window is open. The following cycle's lane codes must show the old word. One cycle later a second read of that address must show the new word. The same reference model also drives the window on and off around memory updates, so gating and rewriting are checked together.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PLAY = 1'b1
    } play_state_e;

endpackage

// File: rtl/wpb_wave_ram.sv
module wpb_wave_ram #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store_q [DEPTH];

    // Both ports update on the same edge; the read samples the array
    // before the non-blocking write lands, giving read-first collisions.
    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
        rdata <= store_q[raddr];
    end

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !$past(we) && raddr == $past(raddr)) |=> $stable(rdata));

    // R7
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we) && raddr == $past(waddr)) |=> (rdata == $past(wdata, 2)));

endmodule

// File: rtl/wpb_lane_unpack.sv
module wpb_lane_unpack #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 14,
    parameter int LSB    = 0
) (
    input  logic [DATA_W-1:0] word,
    output logic [LANE_W-1:0] lane
);

    logic unused_word_bits;

    assign lane             = word[LSB +: LANE_W];
    assign unused_word_bits = ^word;

endmodule

// File: rtl/wpb_gate_fsm.sv
module wpb_gate_fsm
    import wpb_pkg::*;
#(
    parameter int              LANE_W    = 14,
    parameter logic [LANE_W-1:0] IDLE_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win,
    input  logic [LANE_W-1:0] raw_a,
    input  logic [LANE_W-1:0] raw_b,
    output logic [LANE_W-1:0] dac_a,
    output logic [LANE_W-1:0] dac_b
);

    play_state_e state_q;
    play_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = win ? ST_PLAY : ST_IDLE;
            ST_PLAY: state_d = win ? ST_PLAY : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_PLAY: begin
                dac_a = raw_a;
                dac_b = raw_b;
            end
            default: begin
                dac_a = IDLE_CODE;
                dac_b = IDLE_CODE;
            end
        endcase
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_a == IDLE_CODE && dac_b == IDLE_CODE));

    // R2
    win_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win |=> (state_q == ST_PLAY));

    // R5
    idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win |=> (dac_a == IDLE_CODE && dac_b == IDLE_CODE));

endmodule

// File: rtl/wave_playback.sv
module wave_playback #(
    parameter int          DEPTH      = 1024,
    parameter int          IDX_W      = 16,
    parameter int          DATA_W     = 32,
    parameter int          LANE_W     = 14,
    parameter int          LANE_A_LSB = 0,
    parameter int          LANE_B_LSB = 16,
    parameter logic [13:0] IDLE_CODE  = 14'd0,
    localparam int         AW         = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [IDX_W-1:0]  play_idx,
    input  logic              play_win,
    output logic [LANE_W-1:0] dac_a,
    output logic [LANE_W-1:0] dac_b
);

    localparam int NUM_LANES = 2;

    logic [AW-1:0]     rd_addr;
    logic [DATA_W-1:0] rd_word;
    logic [LANE_W-1:0] lane_raw [NUM_LANES];
    logic              unused_idx_bits;

    assign rd_addr         = play_idx[AW-1:0];
    assign unused_idx_bits = ^play_idx;

    wpb_wave_ram #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (host_we),
        .waddr (host_addr),
        .wdata (host_wdata),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int SLICE_LSB = (g == 0) ? LANE_A_LSB : LANE_B_LSB;
        wpb_lane_unpack #(
            .DATA_W (DATA_W),
            .LANE_W (LANE_W),
            .LSB    (SLICE_LSB)
        ) u_unpack (
            .word (rd_word),
            .lane (lane_raw[g])
        );
    end

    wpb_gate_fsm #(
        .LANE_W    (LANE_W),
        .IDLE_CODE (IDLE_CODE[LANE_W-1:0])
    ) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .win   (play_win),
        .raw_a (lane_raw[0]),
        .raw_b (lane_raw[1]),
        .dac_a (dac_a),
        .dac_b (dac_b)
    );

endmodule

// File: tb/wave_playback_test.sv
module wave_playback_test;

    localparam int          DEPTH = 1024;
    localparam int          AW    = $clog2(DEPTH);
    localparam logic [13:0] IDLE  = 14'h1555;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [15:0] play_idx = '0;
    logic        play_win = 1'b0;
    logic [13:0] dac_a;
    logic [13:0] dac_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] model [DEPTH];
    logic [13:0] exp_a = IDLE;
    logic [13:0] exp_b = IDLE;
    string       tag_a = "R1";
    string       tag_b = "R1";

    always #5 clk = ~clk;

    wave_playback #(.IDLE_CODE(IDLE)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .play_idx   (play_idx),
        .play_win   (play_win),
        .dac_a      (dac_a),
        .dac_b      (dac_b)
    );

    function automatic logic [31:0] patt(input int a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_F00F;
    endfunction

    // Check the outcome of the previous cycle, then drive the next one.
    task automatic step(input bit rst, input bit we, input int addr, input logic [31:0] data,
                        input bit win, input int idx, input string ta, input string tb);
        @(negedge clk);
        checks++;
        if (dac_a !== exp_a) begin
            fails++;
            $display("FAIL %s lane A: got %h expected %h", tag_a, dac_a, exp_a);
        end
        checks++;
        if (dac_b !== exp_b) begin
            fails++;
            $display("FAIL %s lane B: got %h expected %h", tag_b, dac_b, exp_b);
        end
        rst_n      = rst;
        host_we    = we;
        host_addr  = addr[AW-1:0];
        host_wdata = data;
        play_win   = win;
        play_idx   = idx[15:0];
        if (rst && win) begin
            exp_a = model[idx % DEPTH][13:0];
            exp_b = model[idx % DEPTH][29:16];
        end else begin
            exp_a = IDLE;
            exp_b = IDLE;
        end
        tag_a = ta;
        tag_b = tb;
        if (we) model[addr % DEPTH] = data;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                fails++;
                $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] w_clean;
        logic [31:0] w_junk;
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, "R1", "R1");
        for (int k = 0; k < 2; k++) step(1, 0, 0, 0, 0, 0, "R1", "R1");
        // Load every word with the window closed: outputs must stay idle.
        for (int a = 0; a < DEPTH; a++) step(1, 1, a, patt(a), 0, a, "R5", "R5");
        // Sweep past the end of the memory to cover index wrap.
        for (int i = 0; i < 1200; i++)
            step(1, 0, 0, 0, 1, i, (i >= DEPTH) ? "R6" : "R2", (i >= DEPTH) ? "R6" : "R3");
        // Window toggling.
        step(1, 0, 0, 0, 0, 7, "R5", "R5");
        step(1, 0, 0, 0, 1, 9, "R2", "R3");
        step(1, 0, 0, 0, 0, 9, "R5", "R5");
        step(1, 0, 0, 0, 1, 3, "R2", "R3");
        step(1, 0, 0, 0, 1, 4, "R2", "R3");
        // Same-cycle write and read of one address: old word, then new.
        step(1, 1, 40, 32'hDEAD_BEEF, 1, 40, "R8", "R8");
        step(1, 0, 0, 0, 1, 40, "R7", "R7");
        // Write elsewhere during playback, read it later.
        step(1, 1, 300, 32'h1234_8765, 1, 12, "R2", "R3");
        step(1, 0, 0, 0, 1, 13, "R2", "R3");
        step(1, 0, 0, 0, 1, 300, "R7", "R7");
        // Host write with window closed does not reach outputs.
        step(1, 1, 301, 32'h3FFF_3FFF, 0, 301, "R5", "R5");
        step(1, 0, 0, 0, 1, 301, "R7", "R7");
        // Ignored padding bits.
        w_clean = {2'b00, 14'h0ABC, 2'b00, 14'h1234};
        w_junk  = {2'b11, 14'h0ABC, 2'b11, 14'h1234};
        step(1, 1, 500, w_clean, 0, 0, "R5", "R5");
        step(1, 1, 501, w_junk, 0, 0, "R5", "R5");
        step(1, 0, 0, 0, 1, 500, "R4", "R4");
        step(1, 0, 0, 0, 1, 501, "R4", "R4");
        // High index bits ignored.
        step(1, 0, 0, 0, 1, 16'hFC05, "R6", "R6");
        step(1, 0, 0, 0, 1, 16'h83FF, "R6", "R6");
        step(1, 0, 0, 0, 0, 0, "R5", "R5");
        step(1, 0, 0, 0, 0, 0, "R5", "R5");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule